// File: doc/BRIEF.md
# Manually Triggered Word Aligner

This block sits behind a deserializer that delivers 8-bit parallel words with an unknown bit boundary. For each channel it keeps the newest and the previous input word. It scans the 16-bit span they form at all eight bit offsets for a comma pattern, which is a parameter with a default of 8'hBC. A host-controlled enable decides when the boundary may move. While the enable is high, the lane locks onto the offset where the pattern appears. While it is low, the lane keeps using the offset it already has.

Every channel has its own data word, enable bit, pattern-detect bit and sync bit. The sync bit is a one-cycle marker, not a held lock flag: it is high only in the cycle in which the first word at a new boundary is presented. Downstream logic uses pattern-detect to find comma words in the aligned stream. It uses the sync marker to learn that the framing has just changed.

Top module: `manual_word_aligner`

## Requirements
- R1: Each lane holds an offset k in 0..7. The output word is bits [15-k:8-k] of {newest input word, previous input word}, so bit 0 of a word comes first in time. The result is registered, which makes an input word visible on `aligned_data` two clock edges after it is sampled when k is 0.
- R2: A lane moves to a new offset only when three things are true at a clock edge: its enable is high, the pattern occurs in the 16-bit span, and the occurrence is at an offset other than the current one. The word presented at that edge is already taken at the new offset, so it equals the pattern.
- R3: The enable acts by level. A pattern that arrives many cycles after the enable went high still moves the boundary. While the enable is low, the offset is held and pattern occurrences at other offsets are ignored.
- R4: `sync_pulse` for a lane is high for one cycle, in the same cycle as the first word at a new offset, and only when the offset has just moved.
- R5: A pattern found at the current offset while the enable is high causes no move and no `sync_pulse`.
- R6: `comma_seen` for a lane is high exactly when that lane's `aligned_data` word equals the pattern, whatever the level of the enable.
- R7: When the pattern occurs at more than one offset in the same span, the lowest offset is chosen.
- R8: Lanes are independent. Enable bit i, data byte i (bits 8i+7..8i) and status bit i all belong to lane i. Activity on one lane never moves another lane or raises its status bits.
- R9: A synchronous active-high reset sets every offset to 0 and clears the stored words, all output words and all status bits.
- R10: The pattern is a parameter. A value other than 8'hBC is located and reported in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_data | input | NUM_CH*W | Unaligned words, lane i in bits [8i+7:8i] |
| align_en | input | NUM_CH | Per-lane level-sensitive alignment enable |
| aligned_data | output | NUM_CH*W | Registered words at each lane's offset |
| comma_seen | output | NUM_CH | Output word equals the pattern |
| sync_pulse | output | NUM_CH | One-cycle marker of a boundary move |

## Verification
A boundary move and a pattern detection always fall in the same cycle, because the word taken at the new offset is the pattern. The bench sets up this coincidence by placing a comma at a misaligned bit position while the enable is high. It expects `comma_seen` and `sync_pulse` together on that exact cycle, with the word after it taken at the new offset. The opposite case also gets a test: a comma arrives at the offset the lane already holds. There the bench requires `comma_seen` without `sync_pulse`, which shows that detection and re-alignment are judged separately.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int          WA_WORD_W          = 8;
  localparam logic [7:0]  WA_DEFAULT_PATTERN = 8'hBC;
endpackage

// File: rtl/wa_search.sv
// Scans every bit offset of a two-word span for the comma pattern and
// reports the lowest offset that matches.
module wa_search #(
  parameter int             W       = wa_pkg::WA_WORD_W,
  parameter logic [W-1:0]   PATTERN = wa_pkg::WA_DEFAULT_PATTERN
) (
  input  logic [2*W-1:0]          span,
  output logic                    found,
  output logic [$clog2(W)-1:0]    first_off
);
  localparam int OFF_W = $clog2(W);

  logic [W-1:0] hit;

  // Offset k takes bits [2W-1-k : W-k] of the span.
  generate
    for (genvar k = 0; k < W; k++) begin : g_cand
      assign hit[k] = (span[W-k +: W] == PATTERN);
    end
  endgenerate

  // Walk downward so the lowest matching offset is written last.
  always_comb begin
    found     = |hit;
    first_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit[k]) first_off = OFF_W'(k);
    end
  end
endmodule

// File: rtl/wa_lane.sv
// One channel: two-word history, offset register, output selection.
module wa_lane #(
  parameter int             W       = wa_pkg::WA_WORD_W,
  parameter logic [W-1:0]   PATTERN = wa_pkg::WA_DEFAULT_PATTERN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  word_in,
  input  logic          enable,
  output logic [W-1:0]  word_out,
  output logic          comma,
  output logic          moved
);
  localparam int OFF_W = $clog2(W);

  logic [W-1:0]     newest_q;
  logic [W-1:0]     older_q;
  logic [OFF_W-1:0] off_q;
  logic [2*W-1:0]   span;
  logic             found;
  logic [OFF_W-1:0] first_off;
  logic             shift_now;
  logic [OFF_W-1:0] use_off;
  logic [W-1:0]     picked;

  assign span = {newest_q, older_q};

  wa_search #(.W(W), .PATTERN(PATTERN)) u_search (
    .span      (span),
    .found     (found),
    .first_off (first_off)
  );

  // A move happens only on a level-high enable and a fresh offset.
  assign shift_now = enable && found && (first_off != off_q);
  assign use_off   = shift_now ? first_off : off_q;

  always_comb begin
    picked = span[W - int'(use_off) +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      newest_q <= '0;
      older_q  <= '0;
      off_q    <= '0;
      word_out <= '0;
      comma    <= 1'b0;
      moved    <= 1'b0;
    end else begin
      newest_q <= word_in;
      older_q  <= newest_q;
      if (shift_now) off_q <= first_off;
      word_out <= picked;
      comma    <= (picked == PATTERN);
      moved    <= shift_now;
    end
  end
endmodule

// File: rtl/manual_word_aligner.sv
module manual_word_aligner #(
  parameter int             NUM_CH  = 2,
  parameter int             W       = wa_pkg::WA_WORD_W,
  parameter logic [W-1:0]   PATTERN = wa_pkg::WA_DEFAULT_PATTERN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH*W-1:0]   raw_data,
  input  logic [NUM_CH-1:0]     align_en,
  output logic [NUM_CH*W-1:0]   aligned_data,
  output logic [NUM_CH-1:0]     comma_seen,
  output logic [NUM_CH-1:0]     sync_pulse
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      wa_lane #(.W(W), .PATTERN(PATTERN)) u_lane (
        .clk      (clk),
        .rst      (rst),
        .word_in  (raw_data[i*W +: W]),
        .enable   (align_en[i]),
        .word_out (aligned_data[i*W +: W]),
        .comma    (comma_seen[i]),
        .moved    (sync_pulse[i])
      );
    end
  endgenerate
endmodule

// File: rtl/manual_word_aligner_chk.sv
module manual_word_aligner_chk #(
  parameter int             NUM_CH  = 2,
  parameter int             W       = 8,
  parameter logic [W-1:0]   PATTERN = 8'hBC
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_CH-1:0]     align_en,
  input logic [NUM_CH*W-1:0]   aligned_data,
  input logic [NUM_CH-1:0]     comma_seen,
  input logic [NUM_CH-1:0]     sync_pulse
);
  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R9
      rst_clears_chk: assert property (@(posedge clk)
        rst |=> (sync_pulse[i] == 1'b0 && comma_seen[i] == 1'b0 &&
                 aligned_data[i*W +: W] == '0));

      // R6
      comma_tracks_word_chk: assert property (@(posedge clk) disable iff (rst)
        comma_seen[i] == (aligned_data[i*W +: W] == PATTERN));

      // R4
      sync_on_comma_chk: assert property (@(posedge clk) disable iff (rst)
        sync_pulse[i] |-> comma_seen[i]);

      // R3
      sync_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        sync_pulse[i] |-> $past(align_en[i]));
    end
  endgenerate
endmodule

bind manual_word_aligner manual_word_aligner_chk #(
  .NUM_CH (NUM_CH),
  .W      (W),
  .PATTERN(PATTERN)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .align_en     (align_en),
  .aligned_data (aligned_data),
  .comma_seen   (comma_seen),
  .sync_pulse   (sync_pulse)
);

// File: tb/manual_word_aligner_tb.sv
module manual_word_aligner_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = '0;
  logic [1:0]  en  = '0;
  logic [15:0] dout;
  logic [1:0]  pdet;
  logic [1:0]  sync;
  logic [7:0]  din_a = '0;
  logic        en_a  = 1'b0;
  logic [7:0]  dout_a;
  logic        pdet_a;
  logic        sync_a;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  manual_word_aligner #(.NUM_CH(2)) u_dut (
    .clk(clk), .rst(rst), .raw_data(din), .align_en(en),
    .aligned_data(dout), .comma_seen(pdet), .sync_pulse(sync));

  manual_word_aligner #(.NUM_CH(1), .PATTERN(8'h55)) u_alt (
    .clk(clk), .rst(rst), .raw_data(din_a), .align_en(en_a),
    .aligned_data(dout_a), .comma_seen(pdet_a), .sync_pulse(sync_a));

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Feeds 16 bytes of a bit stream (bit 0 first) into one lane. The offset
  // is k0 before cycle sw and k1 from it on; a sync is expected at sw.
  task automatic run_lane(input int ch, input logic [127:0] s, input logic en_v,
                          input int k0, input int k1, input int sw,
                          input logic exp_sync, input string tag);
    for (int m = 0; m < 16; m++) begin
      din = '0;
      din[ch*8 +: 8] = s[8*m +: 8];
      en = '0;
      en[ch] = en_v;
      tick();
      if (m >= 2) begin
        int k;
        logic [7:0] e;
        k = (m >= sw) ? k1 : k0;
        e = s[8*(m-1)-k +: 8];
        check({tag, " R1 word"}, 32'(dout[ch*8 +: 8]), 32'(e));
        check({tag, " R6 comma"}, 32'(pdet[ch]), 32'(e == 8'hBC));
        check({tag, " R4 sync"}, 32'(sync[ch]), 32'(exp_sync && m == sw));
        check({tag, " R8 other lane"}, 32'(sync[1-ch] | pdet[1-ch]), 32'd0);
      end
    end
    en = '0;
    din = '0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(); tick();
    check("R9 reset data", 32'(dout), 32'd0);
    check("R9 reset status", 32'({pdet, sync, pdet_a, sync_a}), 32'd0);
    check("R9 reset alt data", 32'(dout_a), 32'd0);
    rst = 1'b0;
  endtask

  // Misaligned comma with enable held high from the start.
  task automatic t_realign;
    logic [127:0] s = '0;
    s[27 +: 8] = 8'hBC; s[35 +: 8] = 8'h5A; s[43 +: 8] = 8'h33;
    run_lane(0, s, 1'b1, 0, 5, 5, 1'b1, "R2 realign");
  endtask

  // Enable low: a comma at another offset is ignored, one at the held offset
  // is still reported.
  task automatic t_hold;
    logic [127:0] s = '0;
    s[9 +: 8] = 8'hBC; s[35 +: 8] = 8'hBC; s[43 +: 8] = 8'h5A;
    run_lane(0, s, 1'b0, 5, 5, 99, 1'b0, "R3 hold");
  endtask

  task automatic t_same_offset;
    logic [127:0] s = '0;
    s[27 +: 8] = 8'hBC; s[35 +: 8] = 8'h33;
    run_lane(0, s, 1'b1, 5, 5, 99, 1'b0, "R5 same offset");
  endtask

  // Comma arrives many cycles after enable rose.
  task automatic t_level;
    logic [127:0] s = '0;
    s[49 +: 8] = 8'hBC; s[57 +: 8] = 8'h5A;
    run_lane(0, s, 1'b1, 5, 7, 8, 1'b1, "R3 level");
  endtask

  task automatic t_lane1;
    logic [127:0] s = '0;
    s[22 +: 8] = 8'hBC; s[30 +: 8] = 8'h33;
    run_lane(1, s, 1'b1, 0, 2, 4, 1'b1, "R8 lane1");
  endtask

  // Pattern 8'h55 over an alternating run matches at offsets 6 and 4.
  task automatic t_lowest;
    logic [127:0] s = '0;
    s[18 +: 10] = 10'b0101010101;
    for (int m = 0; m < 16; m++) begin
      din_a = s[8*m +: 8];
      en_a  = (m <= 4);
      tick();
      if (m >= 2) begin
        int k;
        logic [7:0] e;
        k = (m >= 4) ? 4 : 0;
        e = s[8*(m-1)-k +: 8];
        check("R7 R10 word", 32'(dout_a), 32'(e));
        check("R10 comma", 32'(pdet_a), 32'(e == 8'h55));
        check("R7 sync", 32'(sync_a), 32'(m == 4));
      end
    end
    en_a = 1'b0;
    din_a = '0;
  endtask

  task automatic t_reset_mid;
    logic [127:0] s = '0;
    s[16 +: 8] = 8'h5A;
    rst = 1'b1;
    tick();
    check("R9 mid reset", 32'({dout, pdet, sync}), 32'd0);
    rst = 1'b0;
    run_lane(0, s, 1'b0, 0, 0, 99, 1'b0, "R9 offset cleared");
  endtask

  initial begin
    t_reset();
    t_realign();
    t_hold();
    t_same_offset();
    t_level();
    t_lane1();
    t_lowest();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule